// File: doc/BRIEF.md
# Opportunistic Instruction Prefetch Buffer

This block sits between a single-issue core and the one word-wide memory port that the core also uses for data. Instructions come in two sizes, 16 and 32 bits, and a 32-bit instruction may begin on any halfword. Each memory word is little-endian: the halfword at the lower address is in bits 15:0.

The block fetches the next 32-bit instruction word only in cycles when the executing instruction leaves the port free. A load or store takes the port, so no fetch happens in that cycle. The fetch pattern therefore follows directly from the instruction stream and can be worked out at compile time. Fetched words are split into halfwords and placed in a small queue. From the head of that queue the decoder receives either one 16-bit instruction or one whole 32-bit instruction, together with a size flag and the address of the instruction.

A branch redirect clears the queue and restarts fetching at the target. If the queue runs dry, the block forces one fetch even when the stalled instruction would otherwise hold the port.

Top module: `ifb_prefetch`

## Requirements
- R1: While reset is asserted, `dec_valid` is low and `dec_pc` equals the reset program address (0 by default).
- R2: When `mem_busy` is high and an instruction is ready (`dec_valid` high), `mem_req` stays low.
- R3: When no instruction can be issued, no fetch is outstanding and no redirect is present, `mem_req` is driven high whatever `mem_busy` says.
- R4: `mem_addr` is always word-aligned (bits 1:0 zero). Successive requests after a redirect step by 4 bytes, starting from the word that contains the target. Read data is taken from `mem_rdata` exactly one cycle after the request.
- R5: Bits 15:0 of a fetched word enter the queue before bits 31:16.
- R6: A halfword whose bits 15:12 are all ones starts a 32-bit instruction. It is presented as `{first, second}` with `dec_wide` high, and `dec_valid` stays low until both halfwords are held. Any other halfword is a 16-bit instruction, presented as `{16'h0000, hw}` with `dec_wide` low.
- R7: An instruction is issued when `dec_valid` and `dec_ready` are both high. On issue, `dec_pc` advances by 4 for a 32-bit instruction and by 2 for a 16-bit one.
- R8: While `dec_ready` is low (for example during a multi-cycle divide), a valid instruction and its address stay unchanged.
- R9: In a cycle with `redir_valid` high, no request is made. A response arriving in that cycle is dropped. In the next cycle `dec_valid` is low and `dec_pc` equals the target.
- R10: When the target has bit 1 set, the lower halfword of the first word fetched after the redirect is discarded, so the first instruction presented is the one at the target.
- R11: Held plus in-flight halfwords never exceed the capacity of 2×WORDS. With the core stalled and the port free, exactly WORDS requests follow an aligned redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | Branch redirect this cycle |
| redir_addr | input | AW | Halfword-aligned redirect target |
| mem_busy | input | 1 | Executing instruction uses the memory port this cycle |
| mem_req | output | 1 | Instruction fetch request |
| mem_addr | output | AW | Word-aligned fetch address |
| mem_rdata | input | 32 | Read data, valid one cycle after a request |
| dec_valid | output | 1 | An instruction is presented |
| dec_ready | input | 1 | Core accepts the presented instruction |
| dec_instr | output | 32 | Instruction bits |
| dec_wide | output | 1 | High for a 32-bit instruction |
| dec_pc | output | AW | Address of the presented instruction |

## Verification
The bench drives an instruction image in which 32-bit instructions regularly straddle word boundaries. A design that splits such an instruction would emit half an instruction, or would raise `dec_valid` one cycle early. Long stretches with `mem_busy` held high check for a deadlock when the queue drains, and they also show any fetch that steals the port while instructions are still ready. Redirects arrive at random moments, including cycles where a response is in flight and targets in the upper halfword of a word. A design that let stale data through, or kept the lower halfword, would show a wrong instruction or address right after the branch. A stalled-core phase counts requests to catch an overrun of the queue's capacity.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
    localparam int HALF_W = 16;
    localparam logic [3:0] WIDE_MARK = 4'hF;

    typedef logic [HALF_W-1:0] half_t;

    function automatic logic is_wide(input half_t h);
        return h[15:12] == WIDE_MARK;
    endfunction
endpackage

// File: rtl/ifb_hw_queue.sv
module ifb_hw_queue #(
    parameter int DEPTH = 6,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [1:0]           pop_n,
    input  logic [1:0]           wr_n,
    input  ifb_pkg::half_t       wr_h0,
    input  ifb_pkg::half_t       wr_h1,
    output ifb_pkg::half_t       head0,
    output ifb_pkg::half_t       head1,
    output logic [CW-1:0]        count
);
    typedef struct packed {
        logic [DEPTH-1:0][15:0] slot;
        logic [CW-1:0]          cnt;
    } q_state_t;

    q_state_t s_d, s_q;

    always_comb begin
        int pop;
        int base;
        s_d  = s_q;
        pop  = int'(pop_n);
        base = int'(s_q.cnt) - pop;
        if (flush) begin
            s_d.cnt = '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                s_d.slot[i] = (i + pop < DEPTH) ? s_q.slot[i + pop] : '0;
            end
            if (wr_n != 2'd0 && base < DEPTH) s_d.slot[base] = wr_h0;
            if (wr_n == 2'd2 && base + 1 < DEPTH) s_d.slot[base + 1] = wr_h1;
            s_d.cnt = CW'(base + int'(wr_n));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head0 = s_q.slot[0];
    assign head1 = s_q.slot[1];
    assign count = s_q.cnt;
endmodule

// File: rtl/ifb_fetch_ctl.sv
module ifb_fetch_ctl #(
    parameter int             AW       = 16,
    parameter int             DEPTH    = 6,
    parameter int             CW       = $clog2(DEPTH + 1),
    parameter logic [AW-1:0]  RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect,
    input  logic [AW-1:1]   redir_hw,
    input  logic            mem_busy,
    input  logic            dec_valid,
    input  logic [CW-1:0]   count,
    input  logic [31:0]     mem_rdata,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    output logic [1:0]      wr_n,
    output ifb_pkg::half_t  wr_h0,
    output ifb_pkg::half_t  wr_h1,
    output logic            inflight
);
    typedef struct packed {
        logic [AW-1:0] fa;
        logic          inflight;
        logic          skip;
    } f_state_t;

    f_state_t s_d, s_q;
    logic room, starve;

    always_comb begin
        room    = (int'(count) + (s_q.inflight ? 2 : 0) + 2) <= DEPTH;
        starve  = !dec_valid && !s_q.inflight;
        mem_req = !redirect && room && (!mem_busy || starve);

        wr_n  = 2'd0;
        wr_h0 = mem_rdata[15:0];
        wr_h1 = mem_rdata[31:16];
        if (s_q.inflight && !redirect) begin
            if (s_q.skip) begin
                wr_n  = 2'd1;
                wr_h0 = mem_rdata[31:16];
            end else begin
                wr_n  = 2'd2;
            end
        end

        s_d = s_q;
        if (redirect) begin
            s_d.fa       = {redir_hw[AW-1:2], 2'b00};
            s_d.skip     = redir_hw[1];
            s_d.inflight = 1'b0;
        end else begin
            s_d.inflight = mem_req;
            if (mem_req)     s_d.fa   = s_q.fa + AW'(4);
            if (s_q.inflight) s_d.skip = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{fa: {RESET_PC[AW-1:2], 2'b00}, inflight: 1'b0, skip: RESET_PC[1]};
        else        s_q <= s_d;
    end

    assign mem_addr = s_q.fa;
    assign inflight = s_q.inflight;
endmodule

// File: rtl/ifb_issue.sv
module ifb_issue #(
    parameter int             AW       = 16,
    parameter int             CW       = 3,
    parameter logic [AW-1:0]  RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            redirect,
    input  logic [AW-1:0]   redir_addr,
    input  logic            dec_ready,
    input  logic [CW-1:0]   count,
    input  ifb_pkg::half_t  head0,
    input  ifb_pkg::half_t  head1,
    output logic            dec_valid,
    output logic [31:0]     dec_instr,
    output logic            dec_wide,
    output logic [AW-1:0]   dec_pc,
    output logic [1:0]      pop_n
);
    typedef struct packed {
        logic [AW-1:0] pc;
    } i_state_t;

    i_state_t s_d, s_q;
    logic fire;

    always_comb begin
        dec_wide  = ifb_pkg::is_wide(head0);
        dec_valid = (count != '0) && (!dec_wide || count > CW'(1));
        dec_instr = dec_wide ? {head0, head1} : {16'h0000, head0};
        fire      = dec_valid && dec_ready && !redirect;
        pop_n     = fire ? (dec_wide ? 2'd2 : 2'd1) : 2'd0;

        s_d = s_q;
        if (redirect)  s_d.pc = redir_addr;
        else if (fire) s_d.pc = s_q.pc + (dec_wide ? AW'(4) : AW'(2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{pc: RESET_PC};
        else        s_q <= s_d;
    end

    assign dec_pc = s_q.pc;
endmodule

// File: rtl/ifb_prefetch.sv
module ifb_prefetch #(
    parameter int             AW       = 16,
    parameter int             WORDS    = 3,
    parameter logic [AW-1:0]  RESET_PC = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           redir_valid,
    input  logic [AW-1:0]  redir_addr,
    input  logic           mem_busy,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic [31:0]    mem_rdata,
    output logic           dec_valid,
    input  logic           dec_ready,
    output logic [31:0]    dec_instr,
    output logic           dec_wide,
    output logic [AW-1:0]  dec_pc
);
    localparam int DEPTH = 2 * WORDS;
    localparam int CW    = $clog2(DEPTH + 1);

    logic [CW-1:0]  count_w;
    logic [1:0]     pop_w, wr_w;
    ifb_pkg::half_t h0_w, h1_w, wh0_w, wh1_w;
    logic           inflight_w;

    ifb_hw_queue #(.DEPTH(DEPTH), .CW(CW)) u_queue (
        .clk(clk), .rst_n(rst_n), .flush(redir_valid),
        .pop_n(pop_w), .wr_n(wr_w), .wr_h0(wh0_w), .wr_h1(wh1_w),
        .head0(h0_w), .head1(h1_w), .count(count_w)
    );

    ifb_fetch_ctl #(.AW(AW), .DEPTH(DEPTH), .CW(CW), .RESET_PC(RESET_PC)) u_fetch (
        .clk(clk), .rst_n(rst_n), .redirect(redir_valid),
        .redir_hw(redir_addr[AW-1:1]), .mem_busy(mem_busy),
        .dec_valid(dec_valid), .count(count_w), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .wr_n(wr_w), .wr_h0(wh0_w), .wr_h1(wh1_w), .inflight(inflight_w)
    );

    ifb_issue #(.AW(AW), .CW(CW), .RESET_PC(RESET_PC)) u_issue (
        .clk(clk), .rst_n(rst_n), .redirect(redir_valid),
        .redir_addr(redir_addr), .dec_ready(dec_ready),
        .count(count_w), .head0(h0_w), .head1(h1_w),
        .dec_valid(dec_valid), .dec_instr(dec_instr),
        .dec_wide(dec_wide), .dec_pc(dec_pc), .pop_n(pop_w)
    );
endmodule

// File: rtl/ifb_prefetch_chk.sv
module ifb_prefetch_chk #(
    parameter int AW    = 16,
    parameter int DEPTH = 6,
    parameter int CW    = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           redir_valid,
    input logic [AW-1:0]  redir_addr,
    input logic           mem_busy,
    input logic           mem_req,
    input logic [AW-1:0]  mem_addr,
    input logic           dec_valid,
    input logic           dec_ready,
    input logic           dec_wide,
    input logic [AW-1:0]  dec_pc,
    input logic [CW-1:0]  count,
    input logic           inflight
);
    // R2
    busy_port_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_busy && dec_valid) |-> !mem_req);

    // R3
    starve_forces_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && !dec_valid && !inflight) |-> mem_req);

    // R4
    word_aligned_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R6
    wide_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_wide) |-> (count > CW'(1)));

    // R7
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_ready && !redir_valid) |=>
        (dec_pc == $past(dec_pc) + ($past(dec_wide) ? AW'(4) : AW'(2))));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready && !redir_valid) |=> (dec_valid && $stable(dec_pc)));

    // R9
    redir_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> !mem_req);

    // R9
    redir_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> (!dec_valid && dec_pc == $past(redir_addr)));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) + (inflight ? 2 : 0)) <= DEPTH);
endmodule

bind ifb_prefetch ifb_prefetch_chk #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
    .mem_busy(mem_busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_wide(dec_wide),
    .dec_pc(dec_pc), .count(count_w), .inflight(inflight_w)
);

// File: tb/sim_ifb_prefetch.sv
module sim_ifb_prefetch;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 16;
    localparam int WORDS = 3;
    localparam int CAP   = 2 * WORDS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          redir_valid = 1'b0;
    logic [AW-1:0] redir_addr = '0;
    logic          mem_busy = 1'b0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata = 32'hDEAD_BEEF;
    logic          dec_valid;
    logic          dec_ready = 1'b0;
    logic [31:0]   dec_instr;
    logic          dec_wide;
    logic [AW-1:0] dec_pc;

    int checks = 0;
    int errors = 0;
    int nreq   = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifb_prefetch #(.AW(AW), .WORDS(WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_addr(redir_addr),
        .mem_busy(mem_busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .dec_valid(dec_valid), .dec_ready(dec_ready),
        .dec_instr(dec_instr), .dec_wide(dec_wide), .dec_pc(dec_pc)
    );

    // Program image: halfword index ending in 1 or 4 (mod 8) opens a 32-bit instruction.
    function automatic logic [15:0] hw(input logic [15:0] a);
        if (a[3:1] == 3'd1 || a[3:1] == 3'd4) return {4'hF, a[12:1]};
        return {1'b0, a[15:1]};
    endfunction

    function automatic logic [31:0] word_at(input logic [15:0] a);
        return {hw(a + 16'd2), hw(a)};
    endfunction

    function automatic bit wide_hw(input logic [15:0] h);
        return h[15:12] == 4'hF;
    endfunction

    // Memory with one cycle of read latency
    always @(posedge clk) begin
        if (mem_req) mem_rdata <= word_at(mem_addr);
        else         mem_rdata <= 32'hDEAD_BEEF;
    end

    // Reference model state
    logic [15:0] mq[$];
    bit          m_pend;
    logic [15:0] m_paddr, m_fa, m_pc;
    bit          m_skip;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        mq.delete();
        m_pend = 0; m_paddr = '0; m_fa = '0; m_pc = '0; m_skip = 0;
    endtask

    task automatic compare_and_advance();
        bit e_valid, e_wide, e_room, e_req;
        logic [31:0] e_instr, w;
        e_wide  = (mq.size() >= 1) && wide_hw(mq[0]);
        e_valid = (mq.size() >= 1) && (!e_wide || mq.size() >= 2);
        e_room  = (mq.size() + (m_pend ? 2 : 0) + 2) <= CAP;
        e_req   = !redir_valid && e_room && (!mem_busy || (!e_valid && !m_pend));

        if (mem_req) nreq++;
        check(mem_req == e_req, "R2 R3 mem_req", {31'd0, mem_req}, {31'd0, e_req});
        if (e_req) check(mem_addr == m_fa, "R4 mem_addr", {16'd0, mem_addr}, {16'd0, m_fa});
        check(dec_valid == e_valid, "R6 dec_valid", {31'd0, dec_valid}, {31'd0, e_valid});
        if (e_valid) begin
            e_instr = e_wide ? {mq[0], mq[1]} : {16'h0000, mq[0]};
            check(dec_instr == e_instr, "R5 dec_instr", dec_instr, e_instr);
            check(dec_wide == e_wide, "R6 dec_wide", {31'd0, dec_wide}, {31'd0, e_wide});
        end
        check(dec_pc == m_pc, "R7 dec_pc", {16'd0, dec_pc}, {16'd0, m_pc});

        if (redir_valid) begin
            mq.delete();
            m_pend = 0;
            m_fa   = {redir_addr[15:2], 2'b00};
            m_skip = redir_addr[1];
            m_pc   = redir_addr;
        end else begin
            if (e_valid && dec_ready) begin
                void'(mq.pop_front());
                if (e_wide) begin
                    void'(mq.pop_front());
                    m_pc = m_pc + 16'd4;
                end else begin
                    m_pc = m_pc + 16'd2;
                end
            end
            if (m_pend) begin
                w = word_at(m_paddr);
                if (m_skip) begin
                    mq.push_back(w[31:16]);
                    m_skip = 0;
                end else begin
                    mq.push_back(w[15:0]);
                    mq.push_back(w[31:16]);
                end
            end
            if (e_req) begin
                m_pend  = 1;
                m_paddr = m_fa;
                m_fa    = m_fa + 16'd4;
            end else begin
                m_pend = 0;
            end
        end
    endtask

    task automatic cyc(input bit busy, input bit ready, input bit rv, input logic [15:0] ra);
        mem_busy    = busy;
        dec_ready   = ready;
        redir_valid = rv;
        redir_addr  = ra;
        #1;
        compare_and_advance();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        logic [15:0] t, e0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(dec_valid == 1'b0, "R1 dec_valid in reset", {31'd0, dec_valid}, 32'd0);
        check(dec_pc == 16'd0, "R1 dec_pc in reset", {16'd0, dec_pc}, 32'd0);
        rst_n = 1'b1;

        // Plain run from reset, port always free
        for (int i = 0; i < 40; i++) cyc(0, 1, 0, '0);

        // R11: aligned redirect, core stalled, port free -> WORDS requests
        cyc(0, 0, 1, 16'h0100);
        nreq = 0;
        for (int i = 0; i < 12; i++) cyc(0, 0, 0, '0);
        check(nreq == WORDS, "R11 request count while stalled", nreq, WORDS);

        // R8: release the stall and let it drain
        for (int i = 0; i < 20; i++) cyc(0, 1, 0, '0);

        // R10: target in the upper half of a word
        t = 16'h0122;
        cyc(0, 0, 1, t);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, '0);
        e0 = hw(t);
        check(dec_valid == 1'b1, "R10 valid after upper-half target", {31'd0, dec_valid}, 32'd1);
        check(dec_pc == t, "R10 pc after upper-half target", {16'd0, dec_pc}, {16'd0, t});
        check(dec_instr == (wide_hw(e0) ? {e0, hw(t + 16'd2)} : {16'h0, e0}),
              "R10 first instruction", dec_instr,
              wide_hw(e0) ? {e0, hw(t + 16'd2)} : {16'h0, e0});

        // R3: port always busy, fetch only by starvation
        for (int i = 0; i < 200; i++) cyc(1, 1, 0, '0);

        // R9 R8 R2: random traffic with redirects, stalls and busy port
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 3) == 0, ($urandom % 4) != 0, ($urandom % 24) == 0,
                {6'd0, 9'($urandom % 512), 1'b0});
        end

        // R9: redirect immediately after another redirect
        cyc(0, 1, 1, 16'h0040);
        cyc(0, 1, 1, 16'h0082);
        for (int i = 0; i < 30; i++) cyc(0, 1, 0, '0);

        finish_run();
    end
endmodule